// File: doc/BRIEF.md
# Interleaved Integrator Slot Sequencer

This block produces the control timing for four interleaved charge-integrator slots (A, B, C, D) so that input charge is captured in every clock period, with no gap between windows. Each slot moves through four steps on consecutive clocks: integrate, then hold with range selection, then digitize, then clear. The slots are staggered by one clock, so at every cycle exactly one slot sits in each step and a new integration window opens on every edge.

The block also assembles the digitized result. The range decision arrives while a slot is in its select step. The converter mantissa arrives one cycle later, while that slot is digitizing. The range is therefore delayed one cycle so that both parts belong to the same slot. They are packed together with the 2-bit identifier of the producing slot into a registered 14-bit sample with a valid flag. A synchronous realign input restarts the rotation with slot A and holds the valid flag low until the pipeline carries a sample from a window that began after the realign.

Top module: `slot_sequencer`

## Requirements
- R1: After asynchronous reset, integ_stb = 4'b0001 (slot A integrating), sel_stb = 4'b1000, dig_stb = 4'b0100, clr_stb = 4'b0010, and samp_vld = 0. Bit k of every strobe vector refers to slot k (A=0, B=1, C=2, D=3).
- R2: In every cycle each strobe vector has exactly one bit set, and each slot is driven by exactly one of the four strobes.
- R3: Without realign, the integrating slot advances by one each cycle (A, B, C, D, A, ...). Slot k integrates when (cycles since reset or realign − k) mod 4 = 0.
- R4: A slot that integrates in cycle n selects in cycle n+1, digitizes in n+2 and clears in n+3.
- R5: A sample is registered one cycle after its slot digitizes. samp_out[13:12] holds the slot number, and samp_out[9:4] holds mant_in as sampled in the digitize cycle.
- R6: samp_out[11:10] holds range_in as sampled in the cycle before the digitize cycle, which is the select step of the same slot.
- R7: samp_out[3:0] is always 0 when samp_vld is 1.
- R8: When realign is high at a clock edge, integ_stb = 4'b0001 in the following cycle, whatever the phase was before.
- R9: samp_vld is 0 in the three cycles after a realign edge, and after reset. The first valid sample follows in the next cycle and carries slot number 0.
- R10: While realign stays high over several edges, integ_stb stays 4'b0001 and samp_vld stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, one integration window per period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| realign | input | 1 | Synchronous restart of the slot rotation |
| range_in | input | 2 | Range decision of the slot in its select step |
| mant_in | input | 6 | Converter mantissa of the slot in its digitize step |
| integ_stb | output | 4 | One-hot: slot currently integrating |
| sel_stb | output | 4 | One-hot: slot holding and choosing its range |
| dig_stb | output | 4 | One-hot: slot being digitized |
| clr_stb | output | 4 | One-hot: slot being cleared |
| samp_out | output | 14 | {slot id[1:0], range[1:0], mantissa[5:0], 4'b0} |
| samp_vld | output | 1 | samp_out carries a sample from a window begun after the last restart |

## Verification
Two events can fall on the same edge: a realign, and the output stage registering a sample that is already in flight. A realign can also arrive while the fill countdown from an earlier realign is still running. The bench issues realign at several rotation phases, including a three-cycle burst and one issued during steady valid output. It checks that the sample due on that edge is dropped, that the strobes restart at slot A, and that the first valid sample afterwards carries slot 0 together with the range and mantissa the bench drove for that slot.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
  localparam int NSLOT   = 4;
  localparam int IDW     = $clog2(NSLOT);
  localparam int RNG_W   = 2;
  localparam int MANT_W  = 6;
  localparam int TIME_W  = 4;
  localparam int SAMP_W  = IDW + RNG_W + MANT_W + TIME_W;

  typedef enum logic [IDW-1:0] {
    ST_INTEG  = 2'd0,
    ST_SELECT = 2'd1,
    ST_DIGIT  = 2'd2,
    ST_CLEAR  = 2'd3
  } step_e;

  // cycles from range decision to mantissa, and pipeline fill after restart
  localparam int RNG_LAT = int'(ST_DIGIT) - int'(ST_SELECT);
  localparam int FILL    = int'(ST_DIGIT);

  typedef struct packed {
    logic [IDW-1:0]    id;
    logic [RNG_W-1:0]  rng;
    logic [MANT_W-1:0] mant;
    logic [TIME_W-1:0] tcode;
  } samp_t;
endpackage

// File: rtl/iseq_phase_ctr.sv
module iseq_phase_ctr
  import iseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           realign,
  output logic [IDW-1:0] cnt,
  output logic           filled
);
  localparam int HW = $clog2(FILL + 1);

  logic [IDW-1:0] cnt_q, cnt_d;
  logic [HW-1:0]  hold_q, hold_d;
  logic           hold_en;

  always_comb begin
    cnt_d   = realign ? '0 : cnt_q + 1'b1;
    hold_en = realign || (hold_q != '0);
    hold_d  = realign ? HW'(FILL) : hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= HW'(FILL);
    end else begin
      cnt_q <= cnt_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign cnt    = cnt_q;
  assign filled = (hold_q == '0);

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !filled);
endmodule

// File: rtl/iseq_strobe_dec.sv
module iseq_strobe_dec
  import iseq_pkg::*;
(
  input  logic [IDW-1:0]   cnt,
  output logic [NSLOT-1:0] integ,
  output logic [NSLOT-1:0] sel,
  output logic [NSLOT-1:0] dig,
  output logic [NSLOT-1:0] clr
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [IDW-1:0] step;
    assign step     = cnt - IDW'(k);
    assign integ[k] = (step == ST_INTEG);
    assign sel[k]   = (step == ST_SELECT);
    assign dig[k]   = (step == ST_DIGIT);
    assign clr[k]   = (step == ST_CLEAR);
  end
endmodule

// File: rtl/iseq_delay.sv
module iseq_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  if (DEPTH == 0) begin : g_wire
    assign dout = din;
  end else begin : g_regs
    logic [W-1:0] stage_q [DEPTH];
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic [W-1:0] stage_d;
      if (i == 0) begin : g_first
        assign stage_d = din;
      end else begin : g_next
        assign stage_d = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_d;
      end
    end
    assign dout = stage_q[DEPTH-1];
  end
endmodule

// File: rtl/iseq_sample_pack.sv
module iseq_sample_pack
  import iseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              realign,
  input  logic              filled,
  input  logic [IDW-1:0]    dig_id,
  input  logic [RNG_W-1:0]  rng,
  input  logic [MANT_W-1:0] mant,
  output samp_t             samp,
  output logic              vld
);
  samp_t samp_q, samp_d;
  logic  vld_q, vld_d;

  always_comb begin
    samp_d.id    = dig_id;
    samp_d.rng   = rng;
    samp_d.mant  = mant;
    samp_d.tcode = '0;
    vld_d        = filled && !realign;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      samp_q <= samp_d;
      vld_q  <= vld_d;
    end
  end

  assign samp = samp_q;
  assign vld  = vld_q;

  // consecutive valid samples come from consecutive slots
  p_id_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !realign) |=> (samp_q.id == $past(samp_q.id) + 1'b1));
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import iseq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                realign,
  input  logic [RNG_W-1:0]    range_in,
  input  logic [MANT_W-1:0]   mant_in,
  output logic [NSLOT-1:0]    integ_stb,
  output logic [NSLOT-1:0]    sel_stb,
  output logic [NSLOT-1:0]    dig_stb,
  output logic [NSLOT-1:0]    clr_stb,
  output logic [SAMP_W-1:0]   samp_out,
  output logic                samp_vld
);
  logic [IDW-1:0]   cnt;
  logic             filled;
  logic [RNG_W-1:0] rng_d;
  logic [IDW-1:0]   dig_id;
  samp_t            samp;

  iseq_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .realign(realign), .cnt(cnt), .filled(filled)
  );

  iseq_strobe_dec u_dec (
    .cnt(cnt), .integ(integ_stb), .sel(sel_stb), .dig(dig_stb), .clr(clr_stb)
  );

  iseq_delay #(.W(RNG_W), .DEPTH(RNG_LAT)) u_rng_dly (
    .clk(clk), .rst_n(rst_n), .din(range_in), .dout(rng_d)
  );

  assign dig_id = cnt - IDW'(ST_DIGIT);

  iseq_sample_pack u_pack (
    .clk(clk), .rst_n(rst_n), .realign(realign), .filled(filled),
    .dig_id(dig_id), .rng(rng_d), .mant(mant_in), .samp(samp), .vld(samp_vld)
  );

  assign samp_out = samp;

  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(integ_stb) == 1) && ($countones(sel_stb) == 1) &&
    ($countones(dig_stb) == 1) && ($countones(clr_stb) == 1));

  p_slot_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(integ_stb | sel_stb | dig_stb | clr_stb) == NSLOT);

  p_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !realign |=> integ_stb == {$past(integ_stb[NSLOT-2:0]), $past(integ_stb[NSLOT-1])});

  p_step_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !realign |=> (sel_stb == $past(integ_stb)) && (dig_stb == $past(sel_stb)) &&
                 (clr_stb == $past(dig_stb)));

  p_restart_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> integ_stb == NSLOT'(1));

  p_quiet_after_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !samp_vld);
endmodule

// File: tb/sim_slot_sequencer.sv
module sim_slot_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       realign = 1'b0;
  logic [1:0] range_in = '0;
  logic [5:0] mant_in = '0;
  logic [3:0] integ_stb, sel_stb, dig_stb, clr_stb;
  logic [13:0] samp_out;
  logic       samp_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slot_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .realign(realign), .range_in(range_in),
    .mant_in(mant_in), .integ_stb(integ_stb), .sel_stb(sel_stb),
    .dig_stb(dig_stb), .clr_stb(clr_stb), .samp_out(samp_out), .samp_vld(samp_vld)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic bit is_restart(input int i);
    return (i == 37) || (i == 38) || (i == 39) || (i == 101) || (i == 150) || (i == 203);
  endfunction

  initial begin
    int t = 0, hold = 2, since = 100, prev_ra = 0, ra_run = 0;
    bit ev = 1'b0;
    int e_id = 0, e_rg = 0, e_mt = 0, prev_rg = 0;
    #3 rst_n = 1'b0;
    #20;
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 300; i++) begin
      if (i > 0) @(negedge clk);
      // strobes
      if (i == 0) begin
        check("R1 integ", integ_stb, 1);
        check("R1 sel", sel_stb, 8);
        check("R1 dig", dig_stb, 4);
        check("R1 clr", clr_stb, 2);
      end else if (ra_run >= 2) begin
        check("R10 integ held", integ_stb, 1);
      end else if (prev_ra != 0) begin
        check("R8 integ restart", integ_stb, 1);
      end else begin
        check("R3 integ rotate", integ_stb, 1 << (t % 4));
      end
      check("R4 sel", sel_stb, 1 << ((t + 3) % 4));
      check("R4 dig", dig_stb, 1 << ((t + 2) % 4));
      check("R4 clr", clr_stb, 1 << ((t + 1) % 4));
      check("R2 cover", int'(integ_stb | sel_stb | dig_stb | clr_stb), 15);
      check("R2 count", $countones(integ_stb) + $countones(sel_stb) +
            $countones(dig_stb) + $countones(clr_stb), 4);
      // sample
      if (ra_run >= 2) check("R10 vld", samp_vld, 0);
      else check("R9 vld", samp_vld, ev);
      if (ev && samp_vld) begin
        check("R5 id", samp_out[13:12], e_id);
        check("R5 mant", samp_out[9:4], e_mt);
        check("R6 range", samp_out[11:10], e_rg);
        check("R7 tcode", samp_out[3:0], 0);
        if (since == 3) check("R9 first id", samp_out[13:12], 0);
      end
      // drive this cycle
      begin
        int rg, mt;
        bit ra;
        rg = (i * 3 + i / 5) % 4;
        mt = (i * 11 + 5) % 64;
        ra = is_restart(i);
        range_in = 2'(rg);
        mant_in = 6'(mt);
        realign = ra;
        // expected state after next edge
        if (ra) begin
          t = 0; hold = 2; ev = 1'b0; since = 0;
          ra_run = ra_run + 1;
        end else begin
          e_id = (t + 2) % 4;
          e_rg = prev_rg;
          e_mt = mt;
          ev = (hold == 0);
          if (hold > 0) hold = hold - 1;
          t = t + 1;
          since = since + 1;
          ra_run = 0;
        end
        prev_ra = ra;
        prev_rg = rg;
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule